// File: doc/BRIEF.md
# Banked GPIO Unit with Aliased Register Slots

This block gives a UART's byte-wide register port control over sixteen general-purpose pins. The five byte registers that drive the pins have no addresses of their own. They share five register slots with a scratch byte and four flow-control character bytes. A control byte holds three bits: a map bit, a bank bit and a global interrupt enable. While the map bit is clear, the five slots behave as plain read/write storage. While it is set, the same slots reach the pin-level, pin-interrupt-enable, direction, invert and function-select registers, in that slot order.

The pins are wider than the bus, so the bank bit decides which byte of pins the GPIO registers act on: pins 7:0 or pins 15:8. Input pins pass through a two-flop synchronizer. A level-sensitive interrupt is raised while any enabled input pin, after its per-pin polarity inversion, reads 1.

The control bits only act while an enhanced-feature enable input from elsewhere in the UART is high. Writes to the control byte are ignored while that input is low.

Top module: `gpio_alias_unit`

## Requirements
- R1: After reset every pin is an input (`gpio_oe` = 0), every output latch is 0, `irq` is 0, the plain bytes are 0 and every slot reads 0.
- R2: With the effective map bit at 0, slots 0 to 4 act as five independent plain bytes that read back what was written, and writing them changes no pin output or direction.
- R3: With the effective map bit at 1, slot 0 reaches the level register, and slots 1, 2, 3 and 4 reach the interrupt-enable, direction, invert and select registers. Writes in this state leave the plain bytes unchanged.
- R4: Control bit 1 (bank) at 0 makes the GPIO registers act on pins 7:0. At 1 they act on pins 15:8.
- R5: Control bits are bit 0 map, bit 1 bank and bit 2 global interrupt enable, written at slot 5. While `feat_en` is 0, writes to slot 5 are ignored and all three bits act as 0.
- R6: A direction bit of 1 drives that pin's `gpio_oe`. `gpio_out` carries the output latch when the pin's select bit is 0, and the matching `alt_out` bit when it is 1.
- R7: A level-register read returns the latch value for output pins and the synchronized pin value for input pins. A pin change made before a clock edge appears on the read after the second edge.
- R8: `irq` is 1 exactly while the global enable is on and some input pin has its interrupt-enable bit set and (pin value XOR invert bit) = 1. It drops when that condition clears.
- R9: A pin configured as an output never contributes to `irq`.
- R10: Reading slot 5, or any address above 5, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| feat_en | input | 1 | Enhanced-feature enable from the UART |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Slot address (0 to 4 aliased, 5 control) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| gpio_in | input | 16 | Raw pin inputs |
| alt_out | input | 16 | Alternate-function output values |
| gpio_out | output | 16 | Pin output values |
| gpio_oe | output | 16 | Pin output enables |
| irq | output | 1 | Level-sensitive GPIO interrupt |

## Verification
The assertions assume `wr_en` is a single-cycle strobe with `addr` valid in the same cycle. They also assume `feat_en` changes only between register accesses, because the checks on stable control and plain storage compare consecutive cycles. The bench drives every input on the falling clock edge and holds `addr` steady for a whole cycle during reads. It changes `gpio_in` only at a falling edge and then waits out the two synchronizer edges before it expects a result.

// File: rtl/gpio_alias_pkg.sv
// Package: shared constants and types for the aliased GPIO unit.
// Assumes a 3-bit slot address and a 3-bit control byte.
package gpio_alias_pkg;

    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;
    localparam int NREG   = 5;   // aliased slots

    // Slot order is behaviour: the GPIO view decodes these offsets.
    localparam logic [ADDR_W-1:0] SLOT_LVL = 3'd0;
    localparam logic [ADDR_W-1:0] SLOT_IEN = 3'd1;
    localparam logic [ADDR_W-1:0] SLOT_DIR = 3'd2;
    localparam logic [ADDR_W-1:0] SLOT_INV = 3'd3;
    localparam logic [ADDR_W-1:0] SLOT_SEL = 3'd4;
    localparam logic [ADDR_W-1:0] SLOT_CTL = 3'd5;

    // Control byte layout: bit2 global irq enable, bit1 bank, bit0 map.
    typedef struct packed {
        logic gie;
        logic bank;
        logic map;
    } ctl_t;

endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer for asynchronous pin inputs.
// Assumes STAGES >= 2; each bit is synchronized independently.
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                // Later flops shift the sample along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_reg.sv
// Module: per-pin register written one bank (byte of pins) at a time.
// Assumes NPINS is a multiple of BANK_W; the bank index selects the byte.
module gpio_bank_reg #(
    parameter int NPINS  = 16,
    parameter int BANK_W = 8,
    localparam int NBANKS = NPINS / BANK_W,
    localparam int BSEL_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BSEL_W-1:0] bank,
    input  logic [BANK_W-1:0] wdata,
    output logic [NPINS-1:0]  q
);

    // Update only the byte of pins named by the bank index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            for (int b = 0; b < NBANKS; b++) begin
                if (bank == BSEL_W'(b)) q[b*BANK_W +: BANK_W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/alias_plain_regs.sv
// Module: the plain bytes (scratch and four flow characters) that own
// the aliased slots while the GPIO map is off.
// Assumes at most one write strobe is active per cycle.
module alias_plain_regs #(
    parameter int NREG   = 5,
    parameter int BYTE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NREG-1:0]              we,
    input  logic [BYTE_W-1:0]            wdata,
    output logic [NREG-1:0][BYTE_W-1:0]  q
);

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_byte
            // Store one plain byte on its own strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)     q[r] <= '0;
                else if (we[r]) q[r] <= wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_alias_decode.sv
// Module: address decode and read mux for the shared slots.
// Assumes slot indices 0..NREG-1 are aliased and SLOT_CTL is write-only.
module gpio_alias_decode
    import gpio_alias_pkg::*;
(
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        map_eff,
    input  logic                        feat_en,
    input  logic [NREG-1:0][BYTE_W-1:0] gpio_rd,
    input  logic [NREG-1:0][BYTE_W-1:0] plain_rd,
    output logic [NREG-1:0]             gpio_we,
    output logic [NREG-1:0]             plain_we,
    output logic                        ctl_we,
    output logic [BYTE_W-1:0]           rdata
);

    // Steer each aliased-slot write to the GPIO or the plain side.
    always_comb begin
        for (int s = 0; s < NREG; s++) begin
            gpio_we[s]  = wr_en && (addr == ADDR_W'(s)) && map_eff;
            plain_we[s] = wr_en && (addr == ADDR_W'(s)) && !map_eff;
        end
        ctl_we = wr_en && (addr == SLOT_CTL) && feat_en;
    end

    // Return the view currently owning the slot; other addresses read 0.
    always_comb begin
        rdata = '0;
        for (int s = 0; s < NREG; s++) begin
            if (addr == ADDR_W'(s)) rdata = map_eff ? gpio_rd[s] : plain_rd[s];
        end
    end

endmodule

// File: rtl/gpio_alias_unit.sv
// Module: top of the banked GPIO unit with aliased register slots.
// Assumes NPINS = 2 * BYTE_W so one bank bit covers all pins; reset is
// synchronous and active low; gpio_in is asynchronous.
module gpio_alias_unit
    import gpio_alias_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                feat_en,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata,
    input  logic [NPINS-1:0]    gpio_in,
    input  logic [NPINS-1:0]    alt_out,
    output logic [NPINS-1:0]    gpio_out,
    output logic [NPINS-1:0]    gpio_oe,
    output logic                irq
);

    localparam int NBANKS = NPINS / BYTE_W;
    localparam int BSEL_W = (NBANKS > 1) ? $clog2(NBANKS) : 1;
    localparam int NIDX_LVL = 0;
    localparam int NIDX_IEN = 1;
    localparam int NIDX_DIR = 2;
    localparam int NIDX_INV = 3;
    localparam int NIDX_SEL = 4;

    ctl_t                          ctl_q;
    logic [2:0]                    ctl_raw;
    logic                          map_eff;
    logic                          bank_eff;
    logic                          gie_eff;
    logic [NREG-1:0]               gpio_we;
    logic [NREG-1:0]               plain_we;
    logic                          ctl_we;
    logic [NREG-1:0][BYTE_W-1:0]   plain_q;
    logic [NREG*BYTE_W-1:0]        plain_flat;
    logic [NPINS-1:0]              reg_q [NREG];
    logic [NPINS-1:0]              view  [NREG];
    logic [NREG-1:0][BYTE_W-1:0]   gpio_rd;
    logic [NPINS-1:0]              pin_sync;
    logic [NPINS-1:0]              lvl_view;
    logic [NPINS-1:0]              irq_src;

    // Hold the control byte; writes land only while features are enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_t'(wdata[2:0]);
    end

    // Gate every control bit with the feature enable.
    always_comb begin
        map_eff  = ctl_q.map  && feat_en;
        bank_eff = ctl_q.bank && feat_en;
        gie_eff  = ctl_q.gie  && feat_en;
    end

    assign ctl_raw    = ctl_q;
    assign plain_flat = plain_q;

    gpio_alias_decode i_decode (
        .wr_en    (wr_en),
        .addr     (addr),
        .map_eff  (map_eff),
        .feat_en  (feat_en),
        .gpio_rd  (gpio_rd),
        .plain_rd (plain_q),
        .gpio_we  (gpio_we),
        .plain_we (plain_we),
        .ctl_we   (ctl_we),
        .rdata    (rdata)
    );

    alias_plain_regs #(
        .NREG   (NREG),
        .BYTE_W (BYTE_W)
    ) i_plain (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (plain_we),
        .wdata (wdata),
        .q     (plain_q)
    );

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            gpio_bank_reg #(
                .NPINS  (NPINS),
                .BANK_W (BYTE_W)
            ) i_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (gpio_we[r]),
                .bank  (BSEL_W'(bank_eff)),
                .wdata (wdata),
                .q     (reg_q[r])
            );
        end
    endgenerate

    gpio_sync #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gpio_in),
        .q     (pin_sync)
    );

    // Level view: latch for outputs, synchronized pin for inputs.
    always_comb begin
        lvl_view = (reg_q[NIDX_DIR] & reg_q[NIDX_LVL]) |
                   (~reg_q[NIDX_DIR] & pin_sync);
    end

    // Full-width read views, the level slot replaced by the live view.
    always_comb begin
        for (int r = 0; r < NREG; r++) view[r] = reg_q[r];
        view[NIDX_LVL] = lvl_view;
    end

    // Pick the selected bank's byte out of every read view.
    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            gpio_rd[r] = '0;
            for (int b = 0; b < NBANKS; b++) begin
                if (BSEL_W'(bank_eff) == BSEL_W'(b)) gpio_rd[r] = view[r][b*BYTE_W +: BYTE_W];
            end
        end
    end

    // Pin drivers: direction gives enable, select picks latch or alternate.
    always_comb begin
        gpio_oe  = reg_q[NIDX_DIR];
        gpio_out = (reg_q[NIDX_SEL] & alt_out) | (~reg_q[NIDX_SEL] & reg_q[NIDX_LVL]);
    end

    // Level interrupt from enabled inputs after polarity inversion.
    always_comb begin
        irq_src = ~reg_q[NIDX_DIR] & reg_q[NIDX_IEN] & (pin_sync ^ reg_q[NIDX_INV]);
        irq     = gie_eff && (|irq_src);
    end

endmodule

// File: rtl/gpio_alias_checker.sv
// Module: property checker bound to gpio_alias_unit.
// Assumes the single-cycle write strobe described in the brief.
module gpio_alias_checker #(
    parameter int NPINS = 16,
    parameter int PLAIN_W = 40
) (
    input logic               clk,
    input logic               rst_n,
    input logic               feat_en,
    input logic               wr_en,
    input logic [2:0]         addr,
    input logic [NPINS-1:0]   gpio_oe,
    input logic               irq,
    input logic               map_eff,
    input logic               gie_eff,
    input logic [2:0]         ctl_raw,
    input logic [PLAIN_W-1:0] plain_flat
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (gpio_oe == '0 && !irq));

    assert_plain_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (map_eff && wr_en) |=> $stable(plain_flat));

    assert_ctl_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_en |=> $stable(ctl_raw));

    assert_oe_by_dir_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gpio_oe) |-> $past(wr_en && map_eff && addr == 3'd2));

    assert_irq_needs_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie_eff);

    assert_outputs_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (&gpio_oe) |-> !irq);

endmodule

bind gpio_alias_unit gpio_alias_checker #(
    .NPINS   (NPINS),
    .PLAIN_W (gpio_alias_pkg::NREG * gpio_alias_pkg::BYTE_W)
) i_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .feat_en    (feat_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .gpio_oe    (gpio_oe),
    .irq        (irq),
    .map_eff    (map_eff),
    .gie_eff    (gie_eff),
    .ctl_raw    (ctl_raw),
    .plain_flat (plain_flat)
);

// File: tb/test_gpio_alias_unit.sv
// Bench: scoreboard of expected items; a monitor compares after each fall.
module test_gpio_alias_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feat_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] gpio_in = '0;
    logic [15:0] alt_out = '0;
    logic [15:0] gpio_out;
    logic [15:0] gpio_oe;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 rdata, 1 oe, 2 out, 3 irq
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    gpio_alias_unit i_gpio_alias_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .feat_en  (feat_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .gpio_in  (gpio_in),
        .alt_out  (alt_out),
        .gpio_out (gpio_out),
        .gpio_oe  (gpio_oe),
        .irq      (irq)
    );

    // Monitor: pop queued expectations shortly after each falling edge.
    always @(negedge clk) begin
        #2;
        while (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = {8'h00, rdata};
                1:       act = gpio_oe;
                2:       act = gpio_out;
                default: act = {15'd0, irq};
            endcase
            compared++;
            if (act !== it.exp) begin
                mismatched++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic exp_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        addr = a;
        it.kind = 0; it.exp = {8'h00, e}; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic exp_sig(input int k, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.kind = k; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        exp_sig(1, 16'h0000, "R1 oe");
        exp_sig(2, 16'h0000, "R1 out");
        exp_sig(3, 16'h0000, "R1 irq");
        for (int s = 0; s < 5; s++) exp_rd(3'(s), 8'h00, "R1 slot");
        exp_rd(3'd5, 8'h00, "R10 ctl slot");
        exp_rd(3'd7, 8'h00, "R10 high addr");

        // R2 plain storage with map off
        wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h33);
        wr(3'd3, 8'h44); wr(3'd4, 8'h55);
        exp_rd(3'd0, 8'h11, "R2 slot0");
        exp_rd(3'd2, 8'h33, "R2 slot2");
        exp_rd(3'd4, 8'h55, "R2 slot4");
        exp_sig(1, 16'h0000, "R2 oe untouched");

        // R5 control write ignored while features disabled
        wr(3'd5, 8'h01);
        @(negedge clk); feat_en = 1'b1;
        exp_rd(3'd1, 8'h22, "R5 ignored write");
        wr(3'd5, 8'h01);

        // R3 / R6 / R7 bank 0
        wr(3'd2, 8'h0F);
        wr(3'd0, 8'hA5);
        exp_rd(3'd2, 8'h0F, "R3 dir slot");
        exp_sig(1, 16'h000F, "R6 oe");
        exp_sig(2, 16'h00A5, "R6 out latch");
        exp_rd(3'd0, 8'h05, "R7 inputs low");
        @(negedge clk); gpio_in = 16'h12F0;
        exp_rd(3'd0, 8'h05, "R7 one edge");
        exp_rd(3'd0, 8'hF5, "R7 two edges");

        // R4 bank 1
        wr(3'd5, 8'h03);
        exp_rd(3'd2, 8'h00, "R4 bank1 dir");
        wr(3'd2, 8'hF0);
        exp_sig(1, 16'hF00F, "R4 oe high");
        wr(3'd0, 8'h3C);
        exp_sig(2, 16'h3CA5, "R4 out high");
        exp_rd(3'd0, 8'h32, "R4 level high");

        // R3 plain bytes untouched by mapped writes
        wr(3'd5, 8'h00);
        exp_rd(3'd0, 8'h11, "R3 plain0 kept");
        exp_rd(3'd2, 8'h33, "R3 plain2 kept");

        // R6 alternate function select
        wr(3'd5, 8'h01);
        @(negedge clk); alt_out = 16'hFFFF;
        wr(3'd4, 8'h02);
        exp_sig(2, 16'h3CA7, "R6 alt select");
        exp_rd(3'd4, 8'h02, "R3 sel slot");

        // R8 interrupt
        wr(3'd1, 8'h10);
        exp_sig(3, 16'h0000, "R8 gie off");
        wr(3'd5, 8'h05);
        exp_sig(3, 16'h0001, "R8 asserted");
        wr(3'd3, 8'h10);
        exp_sig(3, 16'h0000, "R8 inverted");
        @(negedge clk); gpio_in = 16'h12E0;
        @(negedge clk);
        exp_sig(3, 16'h0001, "R8 pin low inverted");
        wr(3'd1, 8'h00);
        exp_sig(3, 16'h0000, "R8 deassert");

        // R9 output pins never interrupt
        wr(3'd1, 8'h01);
        wr(3'd3, 8'h01);
        exp_sig(3, 16'h0000, "R9 output pin");
        wr(3'd1, 8'h11);
        wr(3'd3, 8'h11);
        exp_sig(3, 16'h0001, "R9 input pin");

        // R5 feature enable gates bits and locks writes
        @(negedge clk); feat_en = 1'b0;
        exp_sig(3, 16'h0000, "R5 irq gated");
        exp_rd(3'd1, 8'h22, "R5 map gated");
        wr(3'd5, 8'h00);
        @(negedge clk); feat_en = 1'b1;
        exp_rd(3'd1, 8'h11, "R5 ctl retained");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule